// File: doc/BRIEF.md
# Segment Limit and Rights Checker

This block checks one memory access against a segment descriptor that has already been fetched and cached. It takes the descriptor's 32-bit base, 20-bit limit, granularity flag and attribute byte, together with a 32-bit offset, the access kind (read, write or execute), the access width and the current and requested privilege levels. From these it forms the 32-bit linear address. It also decides whether the access is allowed, and if not, why.

The decision is combinational and the result is captured in a single register stage. A response appears on the cycle after a request. The limit test scales a page-granular limit. It treats expand-down data segments as valid above the limit rather than below it. The type rules read bit 1 of the attribute byte as a write enable for data segments and as a read enable for code segments. When an access passes, the block returns the attribute byte with its accessed flag set, ready to be written back.

Top module: `seg_guard`

## Requirements
- R1: `lin_addr` equals `desc_base + offset` modulo 2^32. It is registered, and it appears with `rsp_valid` high on the cycle after `req_valid` is high.
- R2: With `desc_gran`=0 the effective limit is the 20-bit limit zero-extended. With `desc_gran`=1 it is the limit shifted left by 12, with twelve one-bits below it.
- R3: For expand-up segments, the access takes a limit fault (cause 4) if `offset` + bytes − 1 exceeds the effective limit. This includes sums that pass FFFFFFFFh. The width code `acc_size` gives 2^`acc_size` bytes (0=1, 1=2, 2=4, 3=8).
- R4: A data segment (attribute bit 3 = 0) with bit 2 = 1 is expand-down. Its access is within limits only when `offset` is greater than the effective limit and `offset` + bytes − 1 does not pass FFFFFFFFh. Otherwise it takes cause 4.
- R5: Attribute bit 7 = 0 (segment absent) gives cause 1.
- R6: Attribute bit 4 = 0 (system descriptor) gives a type fault, cause 2. The unused kind code 3 is also a type fault.
- R7: For a data segment, a write (`acc_kind`=1) with bit 1 = 0 gives cause 2, and any execute (`acc_kind`=2) gives cause 2. A read (`acc_kind`=0) is always allowed by type.
- R8: For a code segment (bit 3 = 1), any write gives cause 2, and a read with bit 1 = 0 gives cause 2. Execute is allowed whatever bit 1 holds.
- R9: For data segments, the larger of `cpl` and `rpl` must not exceed the DPL in bits 6:5, or the access takes cause 3. Code segments are not privilege-checked.
- R10: When several faults apply, the cause reported follows this priority: absent (1) > type (2) > privilege (3) > limit (4). Cause 0 means no fault, and `fault` is high exactly when the cause is non-zero.
- R11: `rights_out` is the request's attribute byte with bit 0 (accessed) set when there is no fault. It is the byte unchanged when there is a fault.
- R12: After reset, all outputs are zero. While `req_valid` is low, `rsp_valid` goes low on the next cycle and the other outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| desc_base | input | 32 | Segment base address |
| desc_limit | input | 20 | Raw segment limit |
| desc_gran | input | 1 | Limit granularity: 0 byte, 1 4 KB |
| desc_rights | input | 8 | Attribute byte (P, DPL, S, E, ED/C, W/R, A) |
| offset | input | 32 | Offset within the segment |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute |
| acc_size | input | 2 | log2 of the access width in bytes |
| cpl | input | 2 | Current privilege level |
| rpl | input | 2 | Requested privilege level |
| rsp_valid | output | 1 | Result valid |
| lin_addr | output | 32 | Linear address |
| fault | output | 1 | Access refused |
| fault_cause | output | 3 | 0 none, 1 absent, 2 type, 3 privilege, 4 limit |
| rights_out | output | 8 | Attribute byte for write-back |

## Verification
The assertions check the cycle-level contract on every cycle:
- a response follows each request and only a request;
- outputs hold while idle;
- an absent segment always reports cause 1;
- a passing access always returns the accessed flag set.

The bench's vector table is the only thing that shows the arithmetic and rule content. That covers granular limit scaling, the inverted range of expand-down segments including their top-of-space edge, wrap-around of the end address, the code and data type rules, and the ordering among simultaneous faults.

// File: rtl/seg_guard_pkg.sv
// Package: shared encodings for the segment checker.
// Assumes the attribute byte layout fixed by the descriptor format.
package seg_guard_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_ABSENT = 3'd1,
        FLT_TYPE   = 3'd2,
        FLT_PRIV   = 3'd3,
        FLT_LIMIT  = 3'd4
    } flt_cause_e;

    // Attribute byte bit positions
    localparam int AB_ACC  = 0;
    localparam int AB_WR   = 1;
    localparam int AB_EDC  = 2;
    localparam int AB_EXE  = 3;
    localparam int AB_SEG  = 4;
    localparam int AB_DPL  = 5;
    localparam int AB_PRES = 7;
endpackage

// File: rtl/seg_limit_unit.sv
// Module: seg_limit_unit
// Combinational range test of one access against a segment limit.
// Scales the raw limit by granularity and handles expand-up and
// expand-down ranges. Assumes ADDR_W > LIMIT_W.
module seg_limit_unit #(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 20,
    parameter int SIZE_W  = 2
) (
    input  logic [LIMIT_W-1:0] raw_limit,
    input  logic               gran,
    input  logic [ADDR_W-1:0]  offset,
    input  logic [SIZE_W-1:0]  size_code,
    input  logic               expand_down,
    output logic               in_range
);
    localparam int GRAN_BITS = ADDR_W - LIMIT_W;

    logic [ADDR_W-1:0] eff_limit;
    logic [ADDR_W:0]   nbytes;
    logic [ADDR_W:0]   last_byte;
    logic              up_ok;
    logic              down_ok;

    // Effective limit: byte-granular or page-granular with low ones
    always_comb begin
        if (gran) eff_limit = {raw_limit, {GRAN_BITS{1'b1}}};
        else      eff_limit = {{GRAN_BITS{1'b0}}, raw_limit};
    end

    // Last byte touched, one bit wider to expose wrap past the top
    always_comb begin
        nbytes    = (ADDR_W+1)'(1) << size_code;
        last_byte = {1'b0, offset} + nbytes - (ADDR_W+1)'(1);
    end

    // Range rules for both directions of growth
    always_comb begin
        up_ok    = (last_byte <= {1'b0, eff_limit});
        down_ok  = (offset > eff_limit) && !last_byte[ADDR_W];
        in_range = expand_down ? down_ok : up_ok;
    end
endmodule

// File: rtl/seg_rights_unit.sv
// Module: seg_rights_unit
// Combinational type and privilege rules from the attribute byte.
// Bit 0 (accessed) is not needed here and is not an input.
module seg_rights_unit
    import seg_guard_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic [7:1]      attr,
    input  logic [1:0]      acc_kind,
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] rpl,
    output logic            present,
    output logic            type_ok,
    output logic            priv_ok,
    output logic            expand_down
);
    logic            is_code;
    logic [PL_W-1:0] dpl;
    logic [PL_W-1:0] eff_pl;

    // Decode fixed attribute fields
    always_comb begin
        present     = attr[AB_PRES];
        is_code     = attr[AB_EXE];
        dpl         = attr[AB_DPL +: PL_W];
        expand_down = !is_code && attr[AB_EDC];
    end

    // Type rules: system descriptors never pass; code and data differ
    always_comb begin
        type_ok = 1'b0;
        if (attr[AB_SEG]) begin
            case (acc_kind)
                ACC_READ:  type_ok = is_code ? attr[AB_WR] : 1'b1;
                ACC_WRITE: type_ok = !is_code && attr[AB_WR];
                ACC_EXEC:  type_ok = is_code;
                default:   type_ok = 1'b0;
            endcase
        end
    end

    // Privilege: data segments only, weakest of current and requested
    always_comb begin
        eff_pl  = (cpl > rpl) ? cpl : rpl;
        priv_ok = is_code || (eff_pl <= dpl);
    end
endmodule

// File: rtl/seg_fault_encode.sv
// Module: seg_fault_encode
// Picks a single fault cause by fixed priority.
// Order: absent, type, privilege, limit.
module seg_fault_encode
    import seg_guard_pkg::*;
(
    input  logic       present,
    input  logic       type_ok,
    input  logic       priv_ok,
    input  logic       in_range,
    output logic [2:0] cause
);
    // Priority chain from most to least fundamental fault
    always_comb begin
        if (!present)      cause = FLT_ABSENT;
        else if (!type_ok) cause = FLT_TYPE;
        else if (!priv_ok) cause = FLT_PRIV;
        else if (!in_range) cause = FLT_LIMIT;
        else               cause = FLT_NONE;
    end
endmodule

// File: rtl/seg_guard.sv
// Module: seg_guard (top)
// Forms the linear address of an access and checks it against a
// cached descriptor. The result is registered one cycle after the
// request. Assumes the descriptor is stable for the request cycle.
module seg_guard
    import seg_guard_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 20,
    parameter int SIZE_W  = 2,
    parameter int PL_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  desc_base,
    input  logic [LIMIT_W-1:0] desc_limit,
    input  logic               desc_gran,
    input  logic [7:0]         desc_rights,
    input  logic [ADDR_W-1:0]  offset,
    input  logic [1:0]         acc_kind,
    input  logic [SIZE_W-1:0]  acc_size,
    input  logic [PL_W-1:0]    cpl,
    input  logic [PL_W-1:0]    rpl,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  lin_addr,
    output logic               fault,
    output logic [2:0]         fault_cause,
    output logic [7:0]         rights_out
);
    logic       present, type_ok, priv_ok, expand_down, in_range;
    logic [2:0] cause_c;

    seg_rights_unit #(.PL_W(PL_W)) u_rights (
        .attr        (desc_rights[7:1]),
        .acc_kind    (acc_kind),
        .cpl         (cpl),
        .rpl         (rpl),
        .present     (present),
        .type_ok     (type_ok),
        .priv_ok     (priv_ok),
        .expand_down (expand_down)
    );

    seg_limit_unit #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .SIZE_W(SIZE_W)) u_limit (
        .raw_limit   (desc_limit),
        .gran        (desc_gran),
        .offset      (offset),
        .size_code   (acc_size),
        .expand_down (expand_down),
        .in_range    (in_range)
    );

    seg_fault_encode u_enc (
        .present  (present),
        .type_ok  (type_ok),
        .priv_ok  (priv_ok),
        .in_range (in_range),
        .cause    (cause_c)
    );

    // Output stage: capture a result on each request, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            lin_addr    <= '0;
            fault       <= 1'b0;
            fault_cause <= FLT_NONE;
            rights_out  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                lin_addr    <= desc_base + offset;
                fault       <= (cause_c != FLT_NONE);
                fault_cause <= cause_c;
                rights_out  <= (cause_c == FLT_NONE)
                               ? (desc_rights | 8'h01) : desc_rights;
            end
        end
    end

    // R12: a response follows every request
    a_r12_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R12: no response without a request
    a_r12_idle_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R12: outputs hold while idle
    a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(lin_addr) && $stable(fault_cause) && $stable(rights_out)));

    // R5: an absent segment always reports the absent cause
    a_r5_absent_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !desc_rights[AB_PRES]) |=> (fault && fault_cause == 3'd1));

    // R11: a passing access returns the accessed flag set
    a_r11_accessed_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !fault) |-> rights_out[AB_ACC]);

    // R10: fault flag and cause agree
    a_r10_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (fault == (fault_cause != 3'd0)));
endmodule

// File: tb/seg_guard_tb_top.sv
// Bench for seg_guard: table-driven vectors, then directed reset/idle tests.
module seg_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] desc_base;
    logic [19:0] desc_limit;
    logic        desc_gran;
    logic [7:0]  desc_rights;
    logic [31:0] offset;
    logic [1:0]  acc_kind;
    logic [1:0]  acc_size;
    logic [1:0]  cpl, rpl;
    logic        rsp_valid;
    logic [31:0] lin_addr;
    logic        fault;
    logic [2:0]  fault_cause;
    logic [7:0]  rights_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    seg_guard dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .desc_base(desc_base), .desc_limit(desc_limit), .desc_gran(desc_gran),
        .desc_rights(desc_rights), .offset(offset), .acc_kind(acc_kind),
        .acc_size(acc_size), .cpl(cpl), .rpl(rpl),
        .rsp_valid(rsp_valid), .lin_addr(lin_addr), .fault(fault),
        .fault_cause(fault_cause), .rights_out(rights_out)
    );

    typedef struct packed {
        logic [31:0] base;
        logic [19:0] lim;
        logic        gran;
        logic [7:0]  rights;
        logic [31:0] off;
        logic [1:0]  kind;
        logic [1:0]  size;
        logic [1:0]  cpl;
        logic [1:0]  rpl;
        logic [31:0] exp_lin;
        logic [2:0]  exp_cause;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam logic [31:0] BS = 32'h0010_0000;
    localparam vec_t VECS [NV] = '{
        '{BS, 20'h001FF, 1'b0, 8'h92, 32'h10, 2'd0, 2'd0, 2'd0, 2'd0, 32'h0010_0010, 3'd0, 4'd1},          // R1 basic read
        '{BS, 20'h001FF, 1'b0, 8'h92, 32'h1FF, 2'd0, 2'd0, 2'd0, 2'd0, 32'h0010_01FF, 3'd0, 4'd2},         // R2 last byte G=0
        '{BS, 20'h001FF, 1'b0, 8'h92, 32'h1FE, 2'd0, 2'd2, 2'd0, 2'd0, 32'h0010_01FE, 3'd4, 4'd3},         // R3 straddles limit
        '{32'h1000_0000, 20'h001FF, 1'b1, 8'h92, 32'h001F_FFFC, 2'd1, 2'd2, 2'd0, 2'd0, 32'h101F_FFFC, 3'd0, 4'd2}, // R2 G=1 top
        '{32'h1000_0000, 20'h001FF, 1'b1, 8'h92, 32'h0020_0000, 2'd0, 2'd0, 2'd0, 2'd0, 32'h1020_0000, 3'd4, 4'd2}, // R2 G=1 over
        '{32'h0, 20'hFFFFF, 1'b1, 8'h92, 32'hFFFF_FFFE, 2'd0, 2'd2, 2'd0, 2'd0, 32'hFFFF_FFFE, 3'd4, 4'd3}, // R3 wrap
        '{32'h0, 20'h00FFF, 1'b0, 8'h96, 32'h0000_0FFF, 2'd0, 2'd0, 2'd0, 2'd0, 32'h0000_0FFF, 3'd4, 4'd4}, // R4 at limit
        '{32'h0, 20'h00FFF, 1'b0, 8'h96, 32'h0000_1000, 2'd1, 2'd0, 2'd0, 2'd0, 32'h0000_1000, 3'd0, 4'd4}, // R4 just above
        '{32'h0, 20'h00FFF, 1'b0, 8'h96, 32'hFFFF_FFFC, 2'd0, 2'd2, 2'd0, 2'd0, 32'hFFFF_FFFC, 3'd0, 4'd4}, // R4 top fits
        '{32'h0, 20'h00FFF, 1'b0, 8'h96, 32'hFFFF_FFFD, 2'd0, 2'd2, 2'd0, 2'd0, 32'hFFFF_FFFD, 3'd4, 4'd4}, // R4 past top
        '{BS, 20'h001FF, 1'b0, 8'h12, 32'h10, 2'd0, 2'd0, 2'd0, 2'd0, 32'h0010_0010, 3'd1, 4'd5},          // R5 absent
        '{BS, 20'h001FF, 1'b0, 8'h02, 32'h10, 2'd1, 2'd0, 2'd3, 2'd3, 32'h0010_0010, 3'd1, 4'd10},         // R10 absent beats type
        '{BS, 20'h001FF, 1'b0, 8'h82, 32'h10, 2'd0, 2'd0, 2'd0, 2'd0, 32'h0010_0010, 3'd2, 4'd6},          // R6 system
        '{BS, 20'h001FF, 1'b0, 8'h90, 32'h10, 2'd1, 2'd0, 2'd0, 2'd0, 32'h0010_0010, 3'd2, 4'd7},          // R7 write RO data
        '{BS, 20'h001FF, 1'b0, 8'h92, 32'h10, 2'd2, 2'd0, 2'd0, 2'd0, 32'h0010_0010, 3'd2, 4'd7},          // R7 exec data
        '{BS, 20'h001FF, 1'b0, 8'h9A, 32'h10, 2'd1, 2'd0, 2'd0, 2'd0, 32'h0010_0010, 3'd2, 4'd8},          // R8 write code
        '{BS, 20'h001FF, 1'b0, 8'h98, 32'h10, 2'd0, 2'd0, 2'd0, 2'd0, 32'h0010_0010, 3'd2, 4'd8},          // R8 read exec-only
        '{BS, 20'h001FF, 1'b0, 8'h98, 32'h10, 2'd2, 2'd0, 2'd0, 2'd0, 32'h0010_0010, 3'd0, 4'd8},          // R8 exec exec-only
        '{BS, 20'h001FF, 1'b0, 8'h92, 32'h10, 2'd0, 2'd0, 2'd3, 2'd0, 32'h0010_0010, 3'd3, 4'd9},          // R9 cpl too weak
        '{BS, 20'h001FF, 1'b0, 8'hD2, 32'h10, 2'd0, 2'd0, 2'd1, 2'd2, 32'h0010_0010, 3'd0, 4'd9},          // R9 equal to DPL
        '{BS, 20'h001FF, 1'b0, 8'hD2, 32'h10, 2'd0, 2'd0, 2'd0, 2'd3, 32'h0010_0010, 3'd3, 4'd9},          // R9 rpl too weak
        '{BS, 20'h001FF, 1'b0, 8'h9A, 32'h10, 2'd2, 2'd0, 2'd3, 2'd3, 32'h0010_0010, 3'd0, 4'd9},          // R9 code unchecked
        '{BS, 20'h001FF, 1'b0, 8'h92, 32'h300, 2'd0, 2'd0, 2'd3, 2'd0, 32'h0010_0300, 3'd3, 4'd10},        // R10 priv beats limit
        '{BS, 20'h001FF, 1'b0, 8'h90, 32'h10, 2'd1, 2'd0, 2'd3, 2'd0, 32'h0010_0010, 3'd2, 4'd10},         // R10 type beats priv
        '{32'hFFFF_FFF0, 20'hFFFFF, 1'b1, 8'h92, 32'h20, 2'd0, 2'd0, 2'd0, 2'd0, 32'h0000_0010, 3'd0, 4'd1}, // R1 address wraps
        '{BS, 20'h001FF, 1'b0, 8'h92, 32'h1F8, 2'd0, 2'd3, 2'd0, 2'd0, 32'h0010_01F8, 3'd0, 4'd3},         // R3 8 bytes fit
        '{BS, 20'h001FF, 1'b0, 8'h92, 32'h1F9, 2'd0, 2'd3, 2'd0, 2'd0, 32'h0010_01F9, 3'd4, 4'd3}          // R3 8 bytes over
    };

    task automatic check(input bit ok, input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R12 watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [31:0] held_lin;
        logic [7:0]  held_rights;
        logic [2:0]  held_cause;
        rst_n = 1'b0; req_valid = 1'b0;
        desc_base = '0; desc_limit = '0; desc_gran = 1'b0; desc_rights = '0;
        offset = '0; acc_kind = '0; acc_size = '0; cpl = '0; rpl = '0;
        repeat (3) @(negedge clk);
        // R12 reset state
        check(rsp_valid == 1'b0, 12, "reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
        check(lin_addr == 32'h0, 12, "reset lin_addr", lin_addr, 32'h0);
        check(fault == 1'b0 && fault_cause == 3'd0, 12, "reset cause", {28'b0, fault, fault_cause}, 32'h0);
        check(rights_out == 8'h0, 12, "reset rights", {24'b0, rights_out}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            desc_base = VECS[i].base; desc_limit = VECS[i].lim;
            desc_gran = VECS[i].gran; desc_rights = VECS[i].rights;
            offset = VECS[i].off; acc_kind = VECS[i].kind; acc_size = VECS[i].size;
            cpl = VECS[i].cpl; rpl = VECS[i].rpl;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            begin
                logic [7:0] exp_r;
                exp_r = (VECS[i].exp_cause == 3'd0) ? (VECS[i].rights | 8'h01) : VECS[i].rights;
                check(rsp_valid, 1, "rsp_valid", {31'b0, rsp_valid}, 32'h1);
                check(lin_addr == VECS[i].exp_lin, 1, "lin_addr", lin_addr, VECS[i].exp_lin);
                check(fault_cause == VECS[i].exp_cause, int'(VECS[i].req), "cause",
                      {29'b0, fault_cause}, {29'b0, VECS[i].exp_cause});
                check(fault == (VECS[i].exp_cause != 3'd0), 10, "fault flag",
                      {31'b0, fault}, {31'b0, (VECS[i].exp_cause != 3'd0)});
                check(rights_out == exp_r, 11, "rights_out", {24'b0, rights_out}, {24'b0, exp_r});
            end
        end

        // R12 idle: new inputs without a request leave outputs alone
        held_lin = lin_addr; held_rights = rights_out; held_cause = fault_cause;
        desc_base = 32'hDEAD_0000; offset = 32'h1234; desc_rights = 8'h12;
        repeat (2) @(negedge clk);
        check(rsp_valid == 1'b0, 12, "idle rsp_valid", {31'b0, rsp_valid}, 32'h0);
        check(lin_addr == held_lin, 12, "idle lin_addr", lin_addr, held_lin);
        check(fault_cause == held_cause, 12, "idle cause", {29'b0, fault_cause}, {29'b0, held_cause});
        check(rights_out == held_rights, 12, "idle rights", {24'b0, rights_out}, {24'b0, held_rights});

        // R12 reset after activity clears everything
        req_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b0, 12, "rerst rsp_valid", {31'b0, rsp_valid}, 32'h0);
        check(lin_addr == 32'h0, 12, "rerst lin_addr", lin_addr, 32'h0);
        check(fault_cause == 3'd0 && !fault, 12, "rerst cause", {28'b0, fault, fault_cause}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule